// File: doc/BRIEF.md
# Windowed Core Watchdog

This block protects a processor against runaway software and stalled bus cycles. Once software arms it through its configuration register, a counter advances on a divided clock. Software must restart that counter at regular intervals by writing a two-byte key to the key register. If the counter reaches the end of the programmed period first, the block responds in the way the configuration selects. It can raise a level interrupt toward the core, issue a one-cycle reset request toward the reset generator, or do both in turn: an interrupt on the first expiry and a reset on a second expiry that comes before any restart.

A window option makes early restarts illegal. The period is split into four equal quarters, and a key write that lands before the last quarter triggers a reset request at once. Software therefore has to restart the counter neither too early nor too late. The block is driven through a plain single-cycle write strobe with an address and a data byte. Once the block is armed, its configuration is frozen until the next reset.

Top module: `core_watchdog`

## Requirements
- R1: After reset the block is disarmed, `irqReq` and `rstReq` are low, and while disarmed the counter does not run and key-register writes have no effect (no window reset, no expiry).
- R2: The configuration register is at address 0. Bit 0 arms the block, bits [3:1] give the period select S, bits [5:4] give the response, and bit 6 enables the window. One period is 2^(9+S) divided-clock ticks, and each tick lasts PRE_DIV clocks.
- R3: Writing 0x55 and then 0xAA to the key register (address 1) while armed restarts the period from zero, so no expiry occurs within the following full period.
- R4: After 0x55, a write of any value other than 0xAA or 0x55 cancels the sequence, and a later 0xAA does not restart the count. A repeated 0x55 leaves the sequence armed.
- R5: With response 00, an expiry sets `irqReq` and does not pulse `rstReq`.
- R6: With response 01, an expiry produces a `rstReq` pulse one clock wide and leaves `irqReq` low.
- R7: With response 10 or 11, the first expiry sets `irqReq`. A second expiry with no restart in between pulses `rstReq` instead.
- R8: A completed key sequence also clears the pending first-expiry state, so the next expiry after it raises an interrupt rather than a reset.
- R9: With the window enabled, any key-register write while the count is below three quarters of the period pulses `rstReq` one cycle later, and that write does not count toward the sequence.
- R10: With the window enabled, a complete key sequence inside the final quarter restarts the period without any reset.
- R11: `irqReq` stays high until a write to the status address (2) with bit 0 set. A status write with bit 0 clear leaves it high.
- R12: While armed, writes to the configuration register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Register address: 0 configuration, 1 key, 2 status |
| wrData | input | DATA_W | Write data |
| irqReq | output | 1 | Level interrupt request to the core |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The bench targets the transitions in the key sequence. A cancelled sequence must not be completed by a late 0xAA, or an interrupt that should come would be lost. A repeated 0x55 must still count, or a correct service would be rejected. In windowed mode, an early write has to produce a reset while a late sequence must not. A design that compared against the wrong quarter would either reset legitimate software or let early servicing through. In the two-stage response, the bench checks that a restart forgets the earlier expiry, since a design that kept the pending state would reset the chip after a properly serviced interrupt. It also checks that a configuration write after arming cannot switch the response from interrupt to reset.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  localparam int SEL_W = 3;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_KEY  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] periodSel;
    logic [1:0]       resp;
    logic             window;
  } cfg_t;

  typedef struct packed {
    logic cntClear;
  } strobe_t;
endpackage

// File: rtl/cwd_datapath.sv
module cwd_datapath
  import cwd_pkg::*;
#(
  parameter int PRE_DIV  = 2,
  parameter int BASE_EXP = 9,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [SEL_W-1:0] periodSel,
  input  strobe_t          strobe,
  output logic             expire,
  output logic             inWindow,
  output logic [CNT_W-1:0] cntValue
);
  logic             tick;
  logic [CNT_W-1:0] periodMask;
  logic [CNT_W-1:0] windowStart;

  generate
    if (PRE_DIV <= 1) begin : g_nodiv
      assign tick = en;
    end else begin : g_div
      localparam int PRE_W = $clog2(PRE_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !en || strobe.cntClear) preCnt <= '0;
        else if (preCnt == PRE_LAST)         preCnt <= '0;
        else                                 preCnt <= preCnt + PRE_W'(1);
      end
      assign tick = en && (preCnt == PRE_LAST);
    end
  endgenerate

  always_comb begin
    periodMask  = ~({CNT_W{1'b1}} << (BASE_EXP + int'(periodSel)));
    windowStart = periodMask - (periodMask >> 2);
  end

  assign expire   = tick && (cntValue == periodMask);
  assign inWindow = (cntValue >= windowStart);

  always_ff @(posedge clk) begin
    if (!rstN || !en || strobe.cntClear) cntValue <= '0;
    else if (tick)                       cntValue <= expire ? '0 : cntValue + CNT_W'(1);
  end
endmodule

// File: rtl/cwd_ctrl.sv
module cwd_ctrl
  import cwd_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  input  logic              inWindow,
  output cfg_t              cfg,
  output strobe_t           strobe,
  output logic              irqReq,
  output logic              rstReq
);
  typedef enum logic {KEY_IDLE, KEY_ARMED} key_e;

  key_e keyState;
  logic cfgWr, keyWr, statWr, badWindow, goodKey, pending;
  logic twoStage, fireIrq, fireRst;

  assign cfgWr     = wrEn && (wrAddr == ADDR_W'(ADDR_CFG));
  assign keyWr     = wrEn && (wrAddr == ADDR_W'(ADDR_KEY)) && cfg.en;
  assign statWr    = wrEn && (wrAddr == ADDR_W'(ADDR_STAT));
  assign badWindow = keyWr && cfg.window && !inWindow;
  assign goodKey   = keyWr && !badWindow && (keyState == KEY_ARMED)
                     && (wrData == DATA_W'(KEY_SECOND));
  assign twoStage  = cfg.resp[1];
  assign fireIrq   = expire && !goodKey
                     && ((cfg.resp == 2'b00) || (twoStage && !pending));
  assign fireRst   = expire && !goodKey
                     && ((cfg.resp == 2'b01) || (twoStage && pending));

  always_comb strobe.cntClear = goodKey;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      keyState <= KEY_IDLE;
      pending  <= 1'b0;
      irqReq   <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      if (cfgWr && !cfg.en)
        cfg <= '{en: wrData[0], periodSel: wrData[3:1],
                 resp: wrData[5:4], window: wrData[6]};

      if (keyWr) begin
        if (!badWindow && wrData == DATA_W'(KEY_FIRST)) keyState <= KEY_ARMED;
        else                                            keyState <= KEY_IDLE;
      end

      if (goodKey)                   pending <= 1'b0;
      else if (expire && twoStage)   pending <= !pending;

      if (fireIrq)                     irqReq <= 1'b1;
      else if (statWr && wrData[0])    irqReq <= 1'b0;

      rstReq <= badWindow || fireRst;
    end
  end
endmodule

// File: rtl/core_watchdog.sv
module core_watchdog
  import cwd_pkg::*;
#(
  parameter int PRE_DIV  = 2,
  parameter int BASE_EXP = 9,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              irqReq,
  output logic              rstReq
);
  cfg_t             cfg;
  strobe_t          strobe;
  logic             expire;
  logic             inWindow;
  logic [CNT_W-1:0] cntValue;

  cwd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .expire(expire), .inWindow(inWindow), .cfg(cfg), .strobe(strobe),
    .irqReq(irqReq), .rstReq(rstReq)
  );

  cwd_datapath #(.PRE_DIV(PRE_DIV), .BASE_EXP(BASE_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .en(cfg.en), .periodSel(cfg.periodSel),
    .strobe(strobe), .expire(expire), .inWindow(inWindow), .cntValue(cntValue)
  );
endmodule

// File: rtl/core_watchdog_chk.sv
module core_watchdog_chk
  import cwd_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqReq,
  input logic              rstReq,
  input cfg_t              cfg,
  input logic              expire,
  input logic              cntClear,
  input logic [CNT_W-1:0]  cntValue
);
  // R1
  irq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> cfg.en);

  // R1
  rst_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> cfg.en);

  // R5
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(expire));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(ADDR_STAT) && wrData[0] && !expire) |=> !irqReq);

  // R12
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.en |=> $stable(cfg));

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> (cntValue == '0));
endmodule

bind core_watchdog core_watchdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irqReq(irqReq), .rstReq(rstReq), .cfg(cfg), .expire(expire),
  .cntClear(strobe.cntClear), .cntValue(cntValue)
);

// File: tb/core_watchdog_tb.sv
module core_watchdog_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       irqReq, rstReq;
  int         total = 0;
  int         bad = 0;
  int         rstCount;

  always #2 clk = ~clk;

  core_watchdog u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqReq(irqReq), .rstReq(rstReq)
  );

  always @(posedge clk) begin
    if (!rstN)       rstCount <= 0;
    else if (rstReq) rstCount <= rstCount + 1;
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic        win;
    logic [11:0] svcAt;
    logic [7:0]  key2;
    logic        expIrq;
    logic [1:0]  expRst;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{2'd0, 1'b0, 12'd0,   8'h00, 1'b1, 2'd0, 4'd5},  // R5 interrupt only
    '{2'd1, 1'b0, 12'd0,   8'h00, 1'b0, 2'd1, 4'd6},  // R6 reset only
    '{2'd2, 1'b0, 12'd0,   8'h00, 1'b1, 2'd0, 4'd7},  // R7 first expiry
    '{2'd0, 1'b0, 12'd500, 8'hAA, 1'b0, 2'd0, 4'd3},  // R3 good sequence
    '{2'd0, 1'b0, 12'd500, 8'h12, 1'b1, 2'd0, 4'd4},  // R4 cancelled
    '{2'd0, 1'b1, 12'd400, 8'hAA, 1'b1, 2'd2, 4'd9},  // R9 early writes
    '{2'd1, 1'b1, 12'd900, 8'hAA, 1'b0, 2'd0, 4'd10}, // R10 late service
    '{2'd2, 1'b1, 12'd900, 8'hAA, 1'b0, 2'd0, 4'd10}  // R10 late, two-stage
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    chk("R1 irq after reset", irqReq, 0);
    chk("R1 rst after reset", rstCount, 0);

    // R1 disarmed: window+reset config written but not armed, key writes ignored
    wr(2'd0, 8'h50);
    wr(2'd1, 8'h12);
    waitCyc(1100);
    chk("R1 disarmed irq", irqReq, 0);
    chk("R1 disarmed rst", rstCount, 0);

    for (int i = 0; i < 8; i++) begin
      vec_t v = VEC[i];
      doReset();
      wr(2'd0, {1'b0, v.win, v.mode, 3'b000, 1'b1});
      if (v.svcAt != 0) begin
        waitCyc(int'(v.svcAt));
        wr(2'd1, 8'h55);
        wr(2'd1, v.key2);
        waitCyc(1040 - int'(v.svcAt) - 2);
      end else begin
        waitCyc(1040);
      end
      chk($sformatf("R%0d vec%0d irq", v.req, i), irqReq, int'(v.expIrq));
      chk($sformatf("R%0d vec%0d rst", v.req, i), rstCount, int'(v.expRst));
    end

    // R2 period select 1 doubles the period
    doReset();
    wr(2'd0, 8'h03);
    waitCyc(1500);
    chk("R2 no expiry before 2^10 ticks", irqReq, 0);
    waitCyc(580);
    chk("R2 expiry after 2^10 ticks", irqReq, 1);

    // R11 status clear
    wr(2'd2, 8'h00);
    chk("R11 bit0 clear keeps irq", irqReq, 1);
    wr(2'd2, 8'h01);
    chk("R11 bit0 set clears irq", irqReq, 0);

    // R12 configuration locked once armed
    doReset();
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h11);
    waitCyc(1040);
    chk("R12 locked irq", irqReq, 1);
    chk("R12 locked rst", rstCount, 0);

    // R7 second expiry resets
    doReset();
    wr(2'd0, 8'h21);
    waitCyc(1040);
    wr(2'd2, 8'h01);
    waitCyc(1060);
    chk("R7 second expiry rst", rstCount, 1);
    chk("R7 second expiry irq", irqReq, 0);

    // R8 restart clears pending state
    doReset();
    wr(2'd0, 8'h21);
    waitCyc(1040);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    wr(2'd2, 8'h01);
    waitCyc(1057);
    chk("R8 next expiry irq", irqReq, 1);
    chk("R8 next expiry rst", rstCount, 0);

    // R4 repeated first key keeps sequence armed
    doReset();
    wr(2'd0, 8'h01);
    waitCyc(500);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    waitCyc(537);
    chk("R4 repeated 0x55 irq", irqReq, 0);
    chk("R4 repeated 0x55 rst", rstCount, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule